// File: doc/BRIEF.md
# MDIO Management Register Front-End

This block lets a host reach the management registers of an Ethernet PHY over the two-wire management bus. The host sees three registers on a simple write strobe interface. The target register takes the PHY address and the register number. The data register returns 16 bits of data together with a busy flag. A command register only accepts writes, and each write to it starts a read. A write to the data register stores the value and starts a write frame. The block makes the management clock from the system clock with a parameterised divider. It runs one clause-22 frame at a time and drives or releases the data line as each frame phase requires.

In normal use the host first polls busy until it is clear. It then loads the target register. To write, it stores the value in the data register. To read, it strikes the command register and polls busy again, and when busy clears the data register holds the word the PHY returned. If nothing answers at the selected address, the pulled-up line reads back as all ones.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the target register is 0, the data register (busy included) is 0, the management clock is low, the data output is 1 and the output enable is 0.
- R2: The management clock runs continuously with a 50 % duty cycle: MDC_HALF system cycles high, then MDC_HALF cycles low.
- R3: A host write with select 1 stores bits 15:0 into the data register and sends a 64-bit frame, MSB first: 32 ones, start 01, opcode 01, PHY address (target bits 9:5), register number (target bits 4:0), turnaround 10, then the 16 data bits. The output enable is high for all 64 bits.
- R4: A host write with select 2 sends a read frame with opcode 10 and the same header. The output enable is high for bits 0 to 45 and low for the two turnaround bits and the 16 data bits.
- R5: In a read, the data line is sampled at each rising edge of the management clock during the 16 data bits. When busy clears, data register bits 15:0 hold those bits, first sampled bit as bit 15.
- R6: A read from a PHY address that never drives the line returns 0xFFFF.
- R7: While busy is set, host writes to the target register (select 0), the data register and the command register have no effect, and no second frame follows.
- R8: Data register bit 16 (busy) is set from the cycle after a start until the falling clock edge that follows the last frame bit. The output enable is low whenever busy is clear.
- R9: The data output changes only on a cycle in which the management clock has just fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 target, 1 data (starts a write), 2 command (starts a read) |
| host_wdata | input | 16 | Host write data |
| addr_reg | output | 10 | Target register: PHY address in 9:5, register number in 4:0 |
| data_reg | output | 17 | Busy in bit 16, data in 15:0 |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench runs a table of frames. It mixes writes and reads at the lowest, highest and mid-range PHY and register addresses, with all-ones, all-zeros, alternating and sparse data, so that a swapped field, a bit-order error or an opcode mix-up shows up in the captured line image. A read from a silent address tells the pull-up path apart from real PHY data. An all-zeros read shows that sampling takes the line value and not a stale or default word. Further tests issue target, data and command writes while a frame is in flight, which separates correct ignoring from a restart or a corrupted header. Reset values and the clock duty cycle are also checked.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int MDC_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [1:0]  host_sel,
  input  logic [15:0] host_wdata,
  output logic [9:0]  addr_reg,
  output logic [16:0] data_reg,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int DW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_GO   = 2'd2;
  localparam logic [6:0] TA_IDX   = 7'd46;
  localparam logic [5:0] DAT_IDX  = 6'd48;
  localparam logic [5:0] LAST_IDX = 6'd63;

  logic [DW-1:0] div_cnt;
  logic          tick, tick_rise, tick_fall;
  logic          busy, active, is_read;
  logic [5:0]    bit_idx;
  logic [63:0]   frame;
  logic [15:0]   data_q;
  logic [9:0]    addr_q;
  logic          start_wr, start_rd;

  assign tick      = (div_cnt == DW'(MDC_HALF - 1));
  assign tick_rise = tick & ~mdc;
  assign tick_fall = tick & mdc;
  assign start_wr  = host_we && (host_sel == SEL_DATA) && !busy;
  assign start_rd  = host_we && (host_sel == SEL_GO) && !busy;
  assign addr_reg  = addr_q;
  assign data_reg  = {busy, data_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      mdc     <= 1'b0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick) mdc <= ~mdc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      busy    <= 1'b0;
      active  <= 1'b0;
      is_read <= 1'b0;
      bit_idx <= '0;
      frame   <= '1;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else begin
      if (host_we && (host_sel == SEL_ADDR) && !busy)
        addr_q <= host_wdata[9:0];
      if (start_wr) begin
        busy    <= 1'b1;
        is_read <= 1'b0;
        data_q  <= host_wdata;
        frame   <= {32'hFFFF_FFFF, 2'b01, 2'b01, addr_q, 2'b10, host_wdata};
      end else if (start_rd) begin
        busy    <= 1'b1;
        is_read <= 1'b1;
        frame   <= {32'hFFFF_FFFF, 2'b01, 2'b10, addr_q, 18'h3FFFF};
      end else if (busy && tick_fall) begin
        if (!active) begin
          active  <= 1'b1;
          bit_idx <= '0;
          mdio_o  <= frame[63];
          mdio_oe <= 1'b1;
          frame   <= {frame[62:0], 1'b1};
        end else if (bit_idx == LAST_IDX) begin
          busy    <= 1'b0;
          active  <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          mdio_o  <= frame[63];
          frame   <= {frame[62:0], 1'b1};
          mdio_oe <= !(is_read && ({1'b0, bit_idx} + 7'd1 >= TA_IDX));
        end
      end else if (busy && active && tick_rise && is_read && bit_idx >= DAT_IDX) begin
        data_q <= {data_q[14:0], mdio_i};
      end
    end
  end

  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(addr_q));

  a_r3_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !is_read) |-> $stable(data_q));

  a_r5_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && data_q != $past(data_q)) |-> $rose(mdc));

  a_r9_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_o != $past(mdio_o)) |-> $fell(mdc));

endmodule

// File: tb/sim_mdio_mgmt_master.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_master;
  localparam int MDC_HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [15:0] host_wdata = 16'd0;
  logic [9:0]  addr_reg;
  logic [16:0] data_reg;
  logic        mdc, mdio_o, mdio_oe, mdio_line;

  int checks = 0;
  int errors = 0;

  logic        phy_en = 1'b0;
  logic [15:0] phy_word = 16'd0;
  logic        busy_s = 1'b0;
  int          fidx = 0;
  int          cur_idx = -1;
  logic [63:0] cap_line = '0;
  logic [63:0] cap_oe = '0;
  logic        prev_o = 1'b1;
  logic        prev_mdc = 1'b0;
  logic        r9_ok = 1'b1;

  always #10 clk = ~clk;

  mdio_mgmt_master #(.MDC_HALF(MDC_HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .addr_reg(addr_reg), .data_reg(data_reg),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  wire phy_drive = phy_en && busy_s && cur_idx >= 47 && cur_idx <= 63;
  wire phy_bit   = (cur_idx == 47) ? 1'b0 : phy_word[(63 - cur_idx) & 15];
  assign mdio_line = mdio_oe ? mdio_o : (phy_drive ? phy_bit : 1'b1);

  always @(negedge clk) begin
    busy_s <= data_reg[16];
    if (rst_n && mdio_o !== prev_o && !(prev_mdc == 1'b1 && mdc == 1'b0)) r9_ok = 1'b0;
    prev_o   <= mdio_o;
    prev_mdc <= mdc;
  end

  always @(negedge mdc) if (busy_s) begin
    cur_idx = fidx;
    fidx = fidx + 1;
  end

  always @(posedge mdc) if (busy_s && cur_idx >= 0 && cur_idx <= 63) begin
    cap_line[63 - cur_idx] = mdio_line;
    cap_oe[63 - cur_idx]   = mdio_oe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = val;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic arm();
    fidx = 0; cur_idx = -1; cap_line = '0; cap_oe = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && data_reg[16]; i++) @(negedge clk);
    @(negedge clk);
  endtask

  // vector: wr, phy[5], reg[5], val[16], respond
  localparam int NV = 7;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 5'd1,  5'd0,  16'h1200, 1'b1},
    {1'b0, 5'd1,  5'd2,  16'h0141, 1'b1},
    {1'b1, 5'd31, 5'd31, 16'hFFFF, 1'b1},
    {1'b0, 5'd0,  5'd5,  16'hA5A5, 1'b1},
    {1'b0, 5'd7,  5'd3,  16'h1234, 1'b0},
    {1'b1, 5'd10, 5'd21, 16'h0000, 1'b1},
    {1'b0, 5'd31, 5'd0,  16'h0000, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 addr", 64'(addr_reg), 64'h0);
    chk("R1 data", 64'(data_reg), 64'h0);
    chk("R1 pins mdc/o/oe", {61'd0, mdc, mdio_o, mdio_oe}, {61'd0, 1'b0, 1'b1, 1'b0});
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic wr; logic [4:0] phy, rg; logic [15:0] val; logic resp;
      logic [63:0] exp_line, exp_oe;
      {wr, phy, rg, val, resp} = VEC[v];
      host_wr(2'd0, {6'd0, phy, rg});
      chk("R3 target layout", 64'(addr_reg), 64'({phy, rg}));
      phy_en = resp; phy_word = val;
      arm();
      host_wr(wr ? 2'd1 : 2'd2, wr ? val : 16'h0);
      chk("R8 busy after start", 64'(data_reg[16]), 64'h1);
      wait_idle();
      chk("R8 busy cleared", 64'(data_reg[16]), 64'h0);
      if (wr) begin
        exp_line = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, val};
        exp_oe   = '1;
        chk("R3 write frame", cap_line, exp_line);
        chk("R3 write enable", cap_oe, exp_oe);
        chk("R3 data kept", 64'(data_reg[15:0]), 64'(val));
      end else begin
        exp_line = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg, 1'b1,
                    resp ? 1'b0 : 1'b1, resp ? val : 16'hFFFF};
        exp_oe   = {46'h3FFF_FFFF_FFFF, 18'h0};
        chk("R4 read frame", cap_line, exp_line);
        chk("R4 read enable", cap_oe, exp_oe);
        if (resp) chk("R5 read data", 64'(data_reg[15:0]), 64'(val));
        else      chk("R6 silent address", 64'(data_reg[15:0]), 64'hFFFF);
      end
      chk("R8 idle released", 64'(mdio_oe), 64'h0);
    end

    // R7: writes while busy are ignored
    host_wr(2'd0, {6'd0, 5'd3, 5'd4});
    phy_en = 1'b1; phy_word = 16'hBEEF;
    arm();
    host_wr(2'd1, 16'h5A5A);
    repeat (20) @(negedge clk);
    host_wr(2'd0, {6'd0, 5'd9, 5'd9});
    host_wr(2'd1, 16'h0F0F);
    host_wr(2'd2, 16'h0);
    chk("R7 addr while busy", 64'(addr_reg), 64'({5'd3, 5'd4}));
    wait_idle();
    chk("R7 frame unchanged", cap_line,
        {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd3, 5'd4, 2'b10, 16'h5A5A});
    chk("R7 data unchanged", 64'(data_reg[15:0]), 64'h5A5A);
    repeat (12) @(negedge clk);
    chk("R7 no second frame", 64'({data_reg[16], mdio_oe}), 64'h0);

    // R2: duty cycle
    begin
      int run = 0; int bad = 0; logic last = mdc; int seen = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (mdc == last) run++;
        else begin
          if (seen > 0 && run != MDC_HALF) bad++;
          seen++; run = 1; last = mdc;
        end
      end
      chk("R2 half periods", 64'(bad), 64'h0);
    end

    chk("R9 output on fall", 64'(r9_ok), 64'h1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule